// File: doc/BRIEF.md
# Top-Four Candidate Rank Sorter

This block receives one set of trigger candidates per bunch crossing. It returns the four candidates with the highest rank, in order. Each candidate carries three fields: a rank, a position code and an isolation flag. The block splits the candidates into two categories, isolated and non-isolated. It sorts each category on its own, so the two top-four lists never mix. A rank of zero marks an empty candidate. Such a candidate never takes a place in either list.

The same module serves both levels of a two-stage tree:

- **First stage.** Two units each take one half of the detector, positive and negative.
- **Second stage.** One unit takes the two top-four lists side by side as its eight inputs. It selects the final four with the same rule.

The pipeline has a fixed depth of two registers. Its outputs are registered, and a valid strobe marks each result.

Top module: `rank_top4_sorter`

## Requirements
- R1: Over the input candidates whose isolation flag (bit 0 of the candidate) is 1, the isolated output carries the four highest ranks. Each output slot is `{rank[9:4], pos[3:0]}` at `out_iso_top[10*k +: 10]`, and a candidate `i` is `{rank[10:5], pos[4:1], iso[0]}` at `in_cand[11*i +: 11]`.
- R2: Over the candidates whose isolation flag is 0, the non-isolated output carries the four highest ranks. No isolated candidate ever appears in it, and no non-isolated candidate appears in the isolated output.
- R3: Within each output, slot 0 holds the highest rank and each later slot holds a rank no larger than the slot before it.
- R4: Among candidates of equal rank, the one with the lower input index takes the earlier output slot.
- R5: When a category has fewer than four non-empty candidates, each unused slot reads as all zeros (rank 0, position 0).
- R6: A candidate of rank 0 is empty and never appears in an output, whatever its position code or flag.
- R7: The outputs for a set sampled with `in_valid` high appear two clock edges later, with `out_valid` high for exactly one cycle per accepted set. Back-to-back sets produce back-to-back results.
- R8: While no set is accepted, both output lists hold their last values, whatever the input bus carries.
- R9: When two ordered top-four lists are fed as inputs 0-3 and 4-7, the output is their merged top four. On equal ranks the entry from the first list comes first.
- R10: After synchronous reset, `out_valid` is 0 and both output lists are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Candidate set on `in_cand` is valid this cycle |
| in_cand | input | 88 | Eight candidates, 11 bits each |
| out_valid | output | 1 | Output lists hold a new result |
| out_iso_top | output | 40 | Four isolated slots, 10 bits each, slot 0 highest |
| out_niso_top | output | 40 | Four non-isolated slots, 10 bits each, slot 0 highest |

## Verification
The hardest situation to reach from the ports is a tie. The order of equal ranks must follow the input index both inside one category and across the two concatenated lists of the cascade. Dedicated vectors set all ranks equal, and they duplicate a rank across the two halves of a merged input. Each duplicate carries a distinct position code, so that a swapped order shows at the outputs. Further vectors mix the isolation flags and give empty candidates non-zero position codes. Two consecutive sets are driven to expose any timing slip in the pipeline.

// File: rtl/rank_sort_pkg.sv
// Shared definitions for the rank sorter.
// Assumes ranks and indices fit in 32 bits.
package rank_sort_pkg;

    // Candidate category carried in the isolation flag
    typedef enum logic {
        CAT_NISO = 1'b0,
        CAT_ISO  = 1'b1
    } cat_e;

    // True when candidate a must be placed ahead of candidate b
    function automatic bit outranks(input int unsigned rank_a, input int unsigned rank_b,
                                    input int unsigned idx_a, input int unsigned idx_b);
        return (rank_a > rank_b) || ((rank_a == rank_b) && (idx_a < idx_b));
    endfunction

endpackage

// File: rtl/cand_split.sv
// Category filter stage.
// It registers the candidates of one category and zeroes every other slot. A zeroed slot
// is one that belongs to the other category or has rank 0; its position is cleared too.
// It assumes a candidate is packed as {rank, pos, iso}, with iso in bit 0.
module cand_split #(
    parameter int N_IN   = 8,
    parameter int RANK_W = 6,
    parameter int POS_W  = 4,
    parameter rank_sort_pkg::cat_e KEEP_CAT = rank_sort_pkg::CAT_ISO
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [N_IN*(RANK_W+POS_W+1)-1:0]   in_cand,
    output logic                               st_valid,
    output logic [N_IN*(RANK_W+POS_W)-1:0]     st_slots
);
    localparam int SLOT_W = RANK_W + POS_W;
    localparam int CAND_W = SLOT_W + 1;

    logic [N_IN*SLOT_W-1:0] kept;

    // Keep only non-empty candidates of the selected category
    always_comb begin
        kept = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (in_cand[i*CAND_W] == KEEP_CAT &&
                in_cand[i*CAND_W+CAND_W-1 -: RANK_W] != '0)
                kept[i*SLOT_W +: SLOT_W] = in_cand[i*CAND_W+1 +: SLOT_W];
        end
    end

    // Stage register: loads on an accepted set, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_slots <= '0;
        end else begin
            st_valid <= in_valid;
            if (in_valid)
                st_slots <= kept;
        end
    end

    AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_valid); // R7

endmodule

// File: rtl/top4_select.sv
// Top-N selector for one category.
// Each slot gets a place number: the count of slots that outrank it, with ties going to
// the lower index. The slot whose place is k goes to output slot k. Empty slots (rank 0)
// are left out, so unused outputs read zero.
// It assumes empty input slots arrive with position zero.
module top4_select
    import rank_sort_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int RANK_W = 6,
    parameter int POS_W  = 4,
    parameter int N_OUT  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [N_IN*(RANK_W+POS_W)-1:0]  in_slots,
    output logic                            out_valid,
    output logic [N_OUT*(RANK_W+POS_W)-1:0] out_slots
);
    localparam int SLOT_W = RANK_W + POS_W;
    localparam int CNT_W  = $clog2(N_IN + 1);

    logic [CNT_W-1:0]        place [N_IN];
    logic [N_OUT*SLOT_W-1:0] pick;

    // Place number of every slot: how many others outrank it
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            place[i] = '0;
            for (int j = 0; j < N_IN; j++) begin
                if (j != i && outranks(32'(in_slots[j*SLOT_W+POS_W +: RANK_W]),
                                       32'(in_slots[i*SLOT_W+POS_W +: RANK_W]),
                                       32'(j), 32'(i)))
                    place[i] = place[i] + CNT_W'(1);
            end
        end
    end

    // Route the slot with place k to output slot k, skipping empties
    always_comb begin
        pick = '0;
        for (int k = 0; k < N_OUT; k++) begin
            for (int i = 0; i < N_IN; i++) begin
                if (in_slots[i*SLOT_W+POS_W +: RANK_W] != '0 && place[i] == CNT_W'(k))
                    pick[k*SLOT_W +: SLOT_W] = in_slots[i*SLOT_W +: SLOT_W];
            end
        end
    end

    // Output register: loads on a valid stage, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slots <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_slots <= pick;
        end
    end

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_slots)); // R8

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        AST_EMPTY_POS: assert property (@(posedge clk) disable iff (!rst_n)
            (out_slots[k*SLOT_W+POS_W +: RANK_W] == '0) |->
            (out_slots[k*SLOT_W +: POS_W] == '0)); // R5
        if (k < N_OUT - 1) begin : g_ord
            AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_slots[k*SLOT_W+POS_W +: RANK_W] >=
                               out_slots[(k+1)*SLOT_W+POS_W +: RANK_W])); // R3
        end
    end

endmodule

// File: rtl/rank_top4_sorter.sv
// Top-four rank sorter.
// It builds two category lanes, isolated and non-isolated, each a filter stage followed by
// a selector. Latency is two clocks. It is cascadable: feed two top-four lists as the
// eight inputs. It assumes one candidate set per bunch-crossing clock at most.
module rank_top4_sorter
    import rank_sort_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int RANK_W = 6,
    parameter int POS_W  = 4,
    parameter int N_OUT  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [N_IN*(RANK_W+POS_W+1)-1:0]    in_cand,
    output logic                                out_valid,
    output logic [N_OUT*(RANK_W+POS_W)-1:0]     out_iso_top,
    output logic [N_OUT*(RANK_W+POS_W)-1:0]     out_niso_top
);
    localparam int SLOT_W = RANK_W + POS_W;

    logic [1:0]              lane_vld;
    logic [1:0]              stage_vld;
    logic [N_OUT*SLOT_W-1:0] lane_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [N_IN*SLOT_W-1:0] stage_slots;

        cand_split #(
            .N_IN(N_IN), .RANK_W(RANK_W), .POS_W(POS_W),
            .KEEP_CAT(g == 1 ? CAT_ISO : CAT_NISO)
        ) u_split (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
            .st_valid(stage_vld[g]), .st_slots(stage_slots)
        );

        top4_select #(
            .N_IN(N_IN), .RANK_W(RANK_W), .POS_W(POS_W), .N_OUT(N_OUT)
        ) u_sel (
            .clk(clk), .rst_n(rst_n), .in_valid(stage_vld[g]), .in_slots(stage_slots),
            .out_valid(lane_vld[g]), .out_slots(lane_out[g])
        );
    end

    assign out_valid    = lane_vld[0] & lane_vld[1];
    assign out_niso_top = lane_out[0];
    assign out_iso_top  = lane_out[1];

    AST_LANES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[0] == lane_vld[1]); // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stage_vld[0]) |-> !out_valid); // R7

endmodule

// File: tb/rank_top4_sorter_tb.sv
module rank_top4_sorter_tb;
    localparam int N  = 8;
    localparam int CW = 11;
    localparam int SW = 10;
    localparam int NV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N*CW-1:0] in_cand = '0;
    logic          out_valid;
    logic [4*SW-1:0] out_iso_top, out_niso_top;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    rank_top4_sorter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cand(in_cand),
        .out_valid(out_valid), .out_iso_top(out_iso_top), .out_niso_top(out_niso_top)
    );

    function automatic logic [CW-1:0] mk(int r, int p, bit iso);
        return {6'(r), 4'(p), iso};
    endfunction

    // Stimulus table, candidate 7 first in each concatenation
    localparam logic [N*CW-1:0] VEC [NV] = '{
        {mk(7,7,1), mk(22,6,1), mk(30,5,1), mk(1,4,1), mk(63,3,1), mk(12,2,1), mk(40,1,1), mk(5,0,1)},
        {mk(8,8,0), mk(17,7,0), mk(2,6,1), mk(61,5,0), mk(50,4,1), mk(10,3,0), mk(33,2,0), mk(33,1,1)},
        {mk(20,8,1), mk(20,9,1), mk(20,10,1), mk(20,11,1), mk(20,12,1), mk(20,13,1), mk(20,14,1), mk(20,15,1)},
        {mk(0,8,1), mk(0,7,0), mk(0,6,1), mk(0,5,0), mk(0,4,1), mk(0,3,0), mk(0,2,1), mk(0,1,0)},
        {mk(0,9,0), mk(3,12,0), mk(14,11,1), mk(0,9,1), mk(0,9,0), mk(9,3,1), mk(0,9,1), mk(0,9,0)},
        {mk(5,12,1), mk(25,11,1), mk(30,10,1), mk(45,9,1), mk(10,4,1), mk(20,3,1), mk(30,2,1), mk(50,1,1)}
    };

    function automatic string tag(int v);
        case (v)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R6";
            4: return "R5";
            default: return "R9";
        endcase
    endfunction

    // Reference: repeated strict-maximum search, lowest index wins ties
    function automatic logic [4*SW-1:0] model(logic [N*CW-1:0] v, bit iso);
        logic [4*SW-1:0] res = '0;
        bit used [N];
        for (int i = 0; i < N; i++) used[i] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
                logic [CW-1:0] c = v[i*CW +: CW];
                if (!used[i] && c[0] == iso && c[10:5] != 0 &&
                    (best < 0 || c[10:5] > v[best*CW+5 +: 6]))
                    best = i;
            end
            if (best >= 0) begin
                used[best] = 1'b1;
                res[k*SW +: SW] = v[best*CW+1 +: SW];
            end
        end
        return res;
    endfunction

    task automatic chk(bit ok, string msg, logic [4*SW-1:0] act, logic [4*SW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic check_out(logic [N*CW-1:0] v, string t);
        chk(out_valid == 1'b1, {t, " R7 valid"}, 40'(out_valid), 40'(1));
        chk(out_iso_top == model(v, 1'b1), {t, " R1 R3 iso"}, out_iso_top, model(v, 1'b1));
        chk(out_niso_top == model(v, 1'b0), {t, " R2 R3 niso"}, out_niso_top, model(v, 1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 valid", 40'(out_valid), 40'(0));
        chk(out_iso_top == '0 && out_niso_top == '0, "R10 lists",
            out_iso_top | out_niso_top, '0);
        rst_n = 1'b1;

        // Table walk, one set at a time
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            in_cand = VEC[v]; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check_out(VEC[v], tag(v));
        end

        // R7: strobe lasts one cycle
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 single pulse", 40'(out_valid), 40'(0));

        // R8: idle input changes do not disturb outputs
        in_cand = VEC[0];
        repeat (3) @(negedge clk);
        chk(out_iso_top == model(VEC[NV-1], 1'b1) && out_niso_top == model(VEC[NV-1], 1'b0),
            "R8 hold", out_iso_top, model(VEC[NV-1], 1'b1));
        chk(out_valid == 1'b0, "R8 no valid", 40'(out_valid), 40'(0));

        // R7: back-to-back sets
        in_cand = VEC[1]; in_valid = 1'b1;
        @(negedge clk);
        in_cand = VEC[2];
        @(negedge clk);
        in_valid = 1'b0; in_cand = VEC[4];
        check_out(VEC[1], "R7 b2b first");
        @(negedge clk);
        check_out(VEC[2], "R7 b2b second");
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 b2b end", 40'(out_valid), 40'(0));

        // R10: reset mid-run clears results
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && out_iso_top == '0 && out_niso_top == '0, "R10 re-reset",
            out_iso_top | out_niso_top, '0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule